// File: doc/BRIEF.md
# Packet Error Detect and Capture Unit

This unit sits beside the logical and transport layers of a packet endpoint and keeps a record of the errors they report. Each error type arrives as a one-cycle pulse on its own line. The fields of the packet that caused it arrive in the same cycle: the address and the source and destination device IDs. The unit keeps a sticky detect bit for every error type. It also keeps an enable mask and a frozen snapshot of the first packet that raised an enabled error.

Software reaches the unit over a simple memory-mapped bus with single-cycle writes and reads. Read data is registered. The interrupt line is high while any detected error has its enable bit set. After a capture, the snapshot stays fixed until software writes the detect register back to all zeros. That write re-arms the snapshot for the next enabled error.

Top module: `err_capture_unit`

## Requirements
- R1: A pulse on bit i of `err_pulse` sets detect bit i at that clock edge. The bit stays set until software clears it.
- R2: A write to byte offset 0x308 leaves detect bit i set where `bus_wdata[i]` is 1 and clears it where `bus_wdata[i]` is 0. An error pulse in the same cycle as a clearing write leaves its bit set.
- R3: Offset 0x30C holds the enable mask. A write loads it from `bus_wdata[NUM_ERR-1:0]`.
- R4: `irq` is high exactly when some detect bit and its enable bit are both set. It changes at the same edge as the registers that cause it.
- R5: When the snapshot is unlocked and a pulse arrives on an enabled error line, that edge loads `pkt_addr` into offset 0x314. The same edge loads the IDs into offset 0x318, with the destination ID in bits [31:16] and the source ID in bits [15:0]. The snapshot is then locked.
- R6: While the snapshot is locked, later errors do not change offsets 0x314 or 0x318.
- R7: When a write leaves the detect register all zeros, the snapshot unlocks. The next enabled error is then captured.
- R8: An error on a line whose enable bit is clear sets its detect bit. It neither loads nor locks the snapshot.
- R9: Reads of any offset other than 0x308, 0x30C, 0x314 and 0x318 return zero. Writes to 0x314 and 0x318 have no effect.
- R10: After a synchronous reset, the detect, enable and snapshot registers read zero, `irq` is low and the snapshot is unlocked.
- R11: A read presents its data on `bus_rdata` after the clock edge at which `bus_rd` is sampled. The data is the register value from before that edge. Register bits above the implemented width read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_pulse | input | NUM_ERR | One pulse per error type |
| pkt_addr | input | CAP_AW | Address of the packet reporting the error |
| pkt_src_id | input | ID_W | Source device ID of that packet |
| pkt_dst_id | input | ID_W | Destination device ID of that packet |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | BUS_AW | Byte offset |
| bus_wdata | input | BUS_DW | Write data |
| bus_rdata | output | BUS_DW | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The directed cases cover the following:
- A first enabled error, followed by a second error that must not displace the snapshot.
- A disabled error, which must set its bit but leave the snapshot unlocked.
- A clearing write in the same cycle as a new error, which tells the precedence rule apart from a plain overwrite.
- Partial clears that leave the detect register nonzero, which tell unlocking on zero apart from unlocking on any write.
- Reads of unmapped offsets and writes to the snapshot.

A random phase then mixes sparse multi-bit error pulses, random masks, writes and reads. A bench model follows it and checks `irq` and read data on every cycle.

// File: rtl/err_mgmt_pkg.sv
package err_mgmt_pkg;
  localparam logic [11:0] OFS_DETECT = 12'h308;
  localparam logic [11:0] OFS_ENABLE = 12'h30C;
  localparam logic [11:0] OFS_CAPADR = 12'h314;
  localparam logic [11:0] OFS_CAPIDS = 12'h318;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DETECT, SEL_ENABLE, SEL_CAPADR, SEL_CAPIDS
  } reg_sel_e;
endpackage

// File: rtl/err_mgmt_status.sv
module err_mgmt_status #(
  parameter int NUM_ERR = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] err_pulse,
  input  logic               det_wr,
  input  logic               en_wr,
  input  logic [NUM_ERR-1:0] wdata,
  output logic [NUM_ERR-1:0] det_q,
  output logic [NUM_ERR-1:0] en_q,
  output logic               irq,
  output logic               capture,
  output logic               locked
);
  logic [NUM_ERR-1:0] det_d, en_d;
  logic               lock_d;

  always_comb begin
    det_d   = (det_wr ? (det_q & wdata) : det_q) | err_pulse;
    en_d    = en_wr ? wdata : en_q;
    capture = (|(err_pulse & en_q)) && !locked;
    if (capture)           lock_d = 1'b1;
    else if (det_d == '0)  lock_d = 1'b0;
    else                   lock_d = locked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      det_q  <= '0;
      en_q   <= '0;
      locked <= 1'b0;
      irq    <= 1'b0;
    end else begin
      det_q  <= det_d;
      en_q   <= en_d;
      locked <= lock_d;
      irq    <= |(det_d & en_d);
    end
  end

  p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(det_wr) |-> ((det_q & $past(det_q)) == $past(det_q)));
  p_err_wins_r2: assert property (@(posedge clk) disable iff (rst)
    ((det_q & $past(err_pulse)) == $past(err_pulse)));
  p_irq_level_r4: assert property (@(posedge clk) disable iff (rst)
    irq == (|(det_q & en_q)));
  p_unlock_r7: assert property (@(posedge clk) disable iff (rst)
    (det_q == '0) |-> !locked);
  p_reset_r10: assert property (@(posedge clk)
    $past(rst) |-> (det_q == '0 && en_q == '0 && !locked && !irq));
endmodule

// File: rtl/err_mgmt_capture.sv
module err_mgmt_capture #(
  parameter int CAP_AW = 32,
  parameter int ID_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              locked,
  input  logic [CAP_AW-1:0] pkt_addr,
  input  logic [ID_W-1:0]   pkt_src_id,
  input  logic [ID_W-1:0]   pkt_dst_id,
  output logic [CAP_AW-1:0] cap_addr,
  output logic [2*ID_W-1:0] cap_ids
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr <= '0;
      cap_ids  <= '0;
    end else if (capture) begin
      cap_addr <= pkt_addr;
      cap_ids  <= {pkt_dst_id, pkt_src_id};
    end
  end

  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    $past(capture) |-> (cap_addr == $past(pkt_addr) &&
                        cap_ids == {$past(pkt_dst_id), $past(pkt_src_id)}));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> ($stable(cap_addr) && $stable(cap_ids)));
endmodule

// File: rtl/err_capture_unit.sv
module err_capture_unit
  import err_mgmt_pkg::*;
#(
  parameter int NUM_ERR = 8,
  parameter int CAP_AW  = 32,
  parameter int ID_W    = 16,
  parameter int BUS_AW  = 12,
  parameter int BUS_DW  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] err_pulse,
  input  logic [CAP_AW-1:0]  pkt_addr,
  input  logic [ID_W-1:0]    pkt_src_id,
  input  logic [ID_W-1:0]    pkt_dst_id,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  output logic [BUS_DW-1:0]  bus_rdata,
  output logic               irq
);
  localparam int IDS_W = 2 * ID_W;

  reg_sel_e           sel;
  logic [NUM_ERR-1:0] det_q, en_q;
  logic               capture, locked;
  logic [CAP_AW-1:0]  cap_addr;
  logic [IDS_W-1:0]   cap_ids;
  logic [BUS_DW-1:0]  rd_d;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata[BUS_DW-1:NUM_ERR];

  always_comb begin
    if      (bus_addr == BUS_AW'(OFS_DETECT)) sel = SEL_DETECT;
    else if (bus_addr == BUS_AW'(OFS_ENABLE)) sel = SEL_ENABLE;
    else if (bus_addr == BUS_AW'(OFS_CAPADR)) sel = SEL_CAPADR;
    else if (bus_addr == BUS_AW'(OFS_CAPIDS)) sel = SEL_CAPIDS;
    else                                      sel = SEL_NONE;
  end

  err_mgmt_status #(.NUM_ERR(NUM_ERR)) u_status (
    .clk       (clk),
    .rst       (rst),
    .err_pulse (err_pulse),
    .det_wr    (bus_wr && sel == SEL_DETECT),
    .en_wr     (bus_wr && sel == SEL_ENABLE),
    .wdata     (bus_wdata[NUM_ERR-1:0]),
    .det_q     (det_q),
    .en_q      (en_q),
    .irq       (irq),
    .capture   (capture),
    .locked    (locked)
  );

  err_mgmt_capture #(.CAP_AW(CAP_AW), .ID_W(ID_W)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .capture    (capture),
    .locked     (locked),
    .pkt_addr   (pkt_addr),
    .pkt_src_id (pkt_src_id),
    .pkt_dst_id (pkt_dst_id),
    .cap_addr   (cap_addr),
    .cap_ids    (cap_ids)
  );

  always_comb begin
    unique case (sel)
      SEL_DETECT: rd_d = BUS_DW'(det_q);
      SEL_ENABLE: rd_d = BUS_DW'(en_q);
      SEL_CAPADR: rd_d = BUS_DW'(cap_addr);
      SEL_CAPIDS: rd_d = BUS_DW'(cap_ids);
      default:    rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(sel) == SEL_NONE) |-> bus_rdata == '0);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/tb_err_capture_unit.sv
module tb_err_capture_unit;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] err_pulse = '0;
  logic [31:0] pkt_addr = '0;
  logic [15:0] pkt_src_id = '0, pkt_dst_id = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, errors = 0;

  logic [N-1:0] m_det = '0, m_en = '0;
  logic         m_lock = 1'b0;
  logic [31:0]  m_addr = '0, m_ids = '0;

  err_capture_unit dut (
    .clk, .rst, .err_pulse, .pkt_addr, .pkt_src_id, .pkt_dst_id,
    .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata, .irq
  );

  always #2 clk = ~clk;

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h308: return 32'(m_det);
      12'h30C: return 32'(m_en);
      12'h314: return m_addr;
      12'h318: return m_ids;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag, input logic [N-1:0] err,
                       input logic [31:0] a, input logic [15:0] s, input logic [15:0] d,
                       input logic wr, input logic rd, input logic [11:0] ofs,
                       input logic [31:0] wd);
    logic [31:0]  exp_rd;
    logic [N-1:0] det_n, en_n;
    logic         cap;
    @(negedge clk);
    err_pulse = err; pkt_addr = a; pkt_src_id = s; pkt_dst_id = d;
    bus_wr = wr; bus_rd = rd; bus_addr = ofs; bus_wdata = wd;
    exp_rd = rd ? model_read(ofs) : bus_rdata;
    det_n = ((wr && ofs == 12'h308) ? (m_det & wd[N-1:0]) : m_det) | err;
    en_n  = (wr && ofs == 12'h30C) ? wd[N-1:0] : m_en;
    cap   = (|(err & m_en)) && !m_lock;
    @(posedge clk);
    #1;
    if (cap) begin m_addr = a; m_ids = {d, s}; end
    m_lock = cap ? 1'b1 : (det_n == '0 ? 1'b0 : m_lock);
    m_det = det_n; m_en = en_n;
    check({tag, " irq (R4)"}, 32'(irq), 32'(|(m_det & m_en)));
    if (rd) check({tag, " rdata (R11)"}, bus_rdata, exp_rd);
    err_pulse = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] ofs, input logic [31:0] exp);
    cycle(tag, '0, 0, 0, 0, 1'b0, 1'b1, ofs, 0);
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    check("R10 irq", 32'(irq), 0);
    rd_chk("R10 detect", 12'h308, 0);
    rd_chk("R10 enable", 12'h30C, 0);
    rd_chk("R10 capaddr", 12'h314, 0);
    rd_chk("R10 capids", 12'h318, 0);
    // R3 enable
    cycle("R3 wr", '0, 0, 0, 0, 1'b1, 1'b0, 12'h30C, 32'hFFFF_FF05);
    rd_chk("R3 enable", 12'h30C, 32'h05);
    // R8 disabled error: no capture
    cycle("R8 err", 8'h02, 32'hDEAD_0001, 16'h11, 16'h22, 1'b0, 1'b0, 0, 0);
    rd_chk("R8 detect", 12'h308, 32'h02);
    rd_chk("R8 capaddr", 12'h314, 0);
    check("R8 irq", 32'(irq), 0);
    // R5 enabled capture
    cycle("R5 err", 8'h04, 32'hCAFE_1234, 16'hA1B2, 16'hC3D4, 1'b0, 1'b0, 0, 0);
    check("R4 irq high", 32'(irq), 1);
    rd_chk("R5 capaddr", 12'h314, 32'hCAFE_1234);
    rd_chk("R5 capids", 12'h318, 32'hC3D4_A1B2);
    // R6 locked
    cycle("R6 err", 8'h01, 32'h5555_AAAA, 16'h1, 16'h2, 1'b0, 1'b0, 0, 0);
    rd_chk("R6 capaddr", 12'h314, 32'hCAFE_1234);
    rd_chk("R1 detect", 12'h308, 32'h07);
    // R9 capture write ignored, unmapped reads zero
    cycle("R9 wr", '0, 0, 0, 0, 1'b1, 1'b0, 12'h314, 32'h1234_5678);
    rd_chk("R9 capaddr", 12'h314, 32'hCAFE_1234);
    rd_chk("R9 unmapped", 12'h300, 0);
    rd_chk("R9 unmapped2", 12'h310, 0);
    // R2 partial clear keeps lock; clear with concurrent error wins
    cycle("R2 clr", 8'h04, 32'h0BAD_0BAD, 16'h3, 16'h4, 1'b1, 1'b0, 12'h308, 32'h1);
    rd_chk("R2 detect", 12'h308, 32'h05);
    rd_chk("R6 capaddr2", 12'h314, 32'hCAFE_1234);
    // R7 full clear unlocks
    cycle("R7 clr", '0, 0, 0, 0, 1'b1, 1'b0, 12'h308, 0);
    check("R7 irq low", 32'(irq), 0);
    cycle("R7 err", 8'h01, 32'h7777_0000, 16'h5, 16'h6, 1'b0, 1'b0, 0, 0);
    rd_chk("R7 capaddr", 12'h314, 32'h7777_0000);
    rd_chk("R7 capids", 12'h318, 32'h0006_0005);
    // random phase, model-checked
    void'($urandom(32'd2024));
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] e;
      logic [2:0]   k;
      logic [11:0]  o;
      e = ($urandom % 6 == 0) ? N'($urandom) : '0;
      k = 3'($urandom % 6);
      o = (k == 0) ? 12'h308 : (k == 1) ? 12'h30C : (k == 2) ? 12'h314 :
          (k == 3) ? 12'h318 : (k == 4) ? 12'h304 : 12'h31C;
      if ($urandom % 4 == 0)
        cycle("R1 R5 R6 R7 R8 rnd wr", e, $urandom, 16'($urandom), 16'($urandom),
              1'b1, 1'b0, o, ($urandom % 3 == 0) ? 32'h0 : $urandom);
      else
        cycle("R2 R3 R9 rnd rd", e, $urandom, 16'($urandom), 16'($urandom),
              1'b0, ($urandom % 2 == 0), o, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule